// File: doc/BRIEF.md
# Masked Interrupt Priority Selector

This block decides, once per clock, whether a processor core should accept an interrupt and, if so, which one. Four request lines arrive: device, clock tick, inter-processor and machine check. A 3-bit interrupt priority level sets which of them may be accepted, and a privileged-mode flag blocks every one of them. Each source has a fixed ceiling level. At or below its ceiling a source is unmasked, so raising the level masks the sources one after another, and level 7 masks them all.

When one or more unmasked requests are pending, the highest-ranked one wins. The block then raises a one-cycle take strobe together with a cause code. Both feed the exception entry logic directly. A small error-code register sits beside the decision. Other exception sources load it through a write strobe, and an accepted interrupt forces it to zero. After every accepted interrupt the block skips one cycle, which gives the entry logic time to raise the privileged-mode flag before another decision is made.

Top module: `irq_prio_sel`

## Requirements
- R1: While `priv_i` is 1 in the sampling cycle, `take_o` stays 0 whatever the requests and level.
- R2: A device request (`req_dev_i`) can be accepted only when `ipl_i` is 0, 1, 2 or 3.
- R3: A clock request (`req_clk_i`) can be accepted only when `ipl_i` is 4 or lower.
- R4: An inter-processor request can be accepted only at level 5 or lower, and a machine-check request only at level 6 or lower. At level 7 nothing is accepted.
- R5: Among the unmasked pending requests the winner is, from highest rank: machine check, inter-processor, clock, device.
- R6: `cause_o` reads 1 for machine check, 2 for inter-processor, 3 for clock and 4 for device while `take_o` is 1, and 0 whenever `take_o` is 0.
- R7: Inputs sampled at a rising edge set `take_o` and `cause_o` from just after that edge until the next one.
- R8: In the cycle after `take_o` was 1, `take_o` is 0 even when requests are still pending. Acceptance resumes the cycle after that.
- R9: When `take_o` rises, `err_code_o` becomes 0 in the same cycle. Without a take, `err_wr_i` loads `err_data_i` into `err_code_o` at the edge. When a take and a write fall in the same cycle, the take wins.
- R10: While `rst_ni` is low, `take_o`, `cause_o` and `err_code_o` are all 0. Reset takes hold without a clock edge and ends on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_dev_i | input | 1 | Device interrupt request |
| req_clk_i | input | 1 | Clock tick interrupt request |
| req_ipi_i | input | 1 | Inter-processor interrupt request |
| req_mchk_i | input | 1 | Machine-check request |
| ipl_i | input | 3 | Current interrupt priority level |
| priv_i | input | 1 | Privileged mode, blocks all interrupts |
| err_wr_i | input | 1 | Load strobe for the error code |
| err_data_i | input | 8 | Error code value to load |
| take_o | output | 1 | One-cycle interrupt accept strobe |
| cause_o | output | 4 | Code of the accepted source |
| err_code_o | output | 8 | Error code register |

## Verification
The hardest case to reach from the ports is the guard cycle. It only appears when requests stay asserted across two consecutive sampling edges. The table walk never produces it, because it inserts an idle cycle after every vector. A directed run therefore holds a clock request for three cycles and expects take, then no take, then take again. A second directed case puts an error-code write in the same cycle as a take, to show that the clear wins.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Source slots, ascending rank: a higher index beats a lower one.
  localparam int NSRC     = 4;
  localparam int SRC_DEV  = 0;
  localparam int SRC_CLK  = 1;
  localparam int SRC_IPI  = 2;
  localparam int SRC_MCHK = 3;

  localparam int CAUSE_W  = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 4'd0,
    CAUSE_MCHK = 4'd1,
    CAUSE_IPI  = 4'd2,
    CAUSE_CLK  = 4'd3,
    CAUSE_DEV  = 4'd4
  } cause_e;

  function automatic cause_e cause_of(input int slot);
    case (slot)
      SRC_DEV:  return CAUSE_DEV;
      SRC_CLK:  return CAUSE_CLK;
      SRC_IPI:  return CAUSE_IPI;
      SRC_MCHK: return CAUSE_MCHK;
      default:  return CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_no = out_q;

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LVL_W = 3,
  parameter int CEIL  = 3
) (
  input  logic             req_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             block_i,
  output logic             elig_o
);

  localparam logic [LVL_W-1:0] CEIL_V = LVL_W'(CEIL);

  logic lvl_ok;

  always_comb begin
    lvl_ok = (ipl_i <= CEIL_V);
    elig_o = req_i & lvl_ok & ~block_i;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i]) grant_o = ONE << i;
    end
    any_o = |elig_i;
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int ERR_W     = 8,
  parameter int DEV_CEIL  = 3,
  parameter int CLK_CEIL  = 4,
  parameter int IPI_CEIL  = 5,
  parameter int MCHK_CEIL = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_dev_i,
  input  logic               req_clk_i,
  input  logic               req_ipi_i,
  input  logic               req_mchk_i,
  input  logic [LVL_W-1:0]   ipl_i,
  input  logic               priv_i,
  input  logic               err_wr_i,
  input  logic [ERR_W-1:0]   err_data_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ERR_W-1:0]   err_code_o
);

  localparam int CEIL [NSRC] = '{DEV_CEIL, CLK_CEIL, IPI_CEIL, MCHK_CEIL};

  logic            rst_n_s;
  logic [NSRC-1:0] req_vec;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic            any_elig;

  logic            take_d,  take_q;
  cause_e          cause_d, cause_q, cause_enc;
  logic [ERR_W-1:0] err_d,  err_q;
  logic            err_en;

  irq_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  assign req_vec[SRC_DEV]  = req_dev_i;
  assign req_vec[SRC_CLK]  = req_clk_i;
  assign req_vec[SRC_IPI]  = req_ipi_i;
  assign req_vec[SRC_MCHK] = req_mchk_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    irq_gate #(
      .LVL_W (LVL_W),
      .CEIL  (CEIL[g])
    ) u_gate (
      .req_i   (req_vec[g]),
      .ipl_i   (ipl_i),
      .block_i (priv_i),
      .elig_o  (elig[g])
    );
  end

  irq_pick #(.N(NSRC)) u_pick (
    .elig_i  (elig),
    .grant_o (grant),
    .any_o   (any_elig)
  );

  // Next-state logic
  always_comb begin
    cause_enc = CAUSE_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) cause_enc = cause_of(i);
    end
    take_d  = any_elig & ~take_q;
    cause_d = take_d ? cause_enc : CAUSE_NONE;
    err_en  = take_d | err_wr_i;
    err_d   = take_d ? '0 : err_data_i;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      take_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      take_q  <= take_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign take_o     = take_q;
  assign cause_o    = cause_q;
  assign err_code_o = err_q;

  AST_PRIV_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $past(priv_i) |-> !take_o);                                       // R1
  AST_DEV_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (take_o && cause_o == CAUSE_DEV) |-> ($past(ipl_i) <= LVL_W'(DEV_CEIL))); // R2
  AST_CLK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (take_o && cause_o == CAUSE_CLK) |-> ($past(ipl_i) <= LVL_W'(CLK_CEIL))); // R3
  AST_TOP_LEVEL_MASKS: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($past(ipl_i) == {LVL_W{1'b1}}) |-> !take_o);                     // R4
  AST_MCHK_WINS: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (take_o && $past(req_mchk_i)) |-> (cause_o == CAUSE_MCHK));       // R5
  AST_CAUSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !take_o |-> (cause_o == CAUSE_NONE));                             // R6
  AST_GUARD_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |=> !take_o);                                              // R8
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |-> (err_code_o == '0));                                   // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!take_o && !$past(err_wr_i)) |-> $stable(err_code_o));           // R9

endmodule

// File: tb/irq_prio_sel_bench.sv
module irq_prio_sel_bench;

  logic       clk;
  logic       rst_n;
  logic       req_dev, req_clk, req_ipi, req_mchk;
  logic [2:0] ipl;
  logic       priv;
  logic       err_wr;
  logic [7:0] err_data;
  logic       take;
  logic [3:0] cause;
  logic [7:0] err_code;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_prio_sel u_irq_prio_sel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_dev_i  (req_dev),
    .req_clk_i  (req_clk),
    .req_ipi_i  (req_ipi),
    .req_mchk_i (req_mchk),
    .ipl_i      (ipl),
    .priv_i     (priv),
    .err_wr_i   (err_wr),
    .err_data_i (err_data),
    .take_o     (take),
    .cause_o    (cause),
    .err_code_o (err_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Entry: {tag, priv, ipl, req{mchk,ipi,clk,dev}, exp_take, exp_cause}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b0, 3'd0, 4'b0001, 1'b1, 4'd4},
    {4'd2, 1'b0, 3'd3, 4'b0001, 1'b1, 4'd4},
    {4'd2, 1'b0, 3'd4, 4'b0001, 1'b0, 4'd0},
    {4'd3, 1'b0, 3'd4, 4'b0010, 1'b1, 4'd3},
    {4'd3, 1'b0, 3'd5, 4'b0010, 1'b0, 4'd0},
    {4'd4, 1'b0, 3'd5, 4'b0100, 1'b1, 4'd2},
    {4'd4, 1'b0, 3'd6, 4'b0100, 1'b0, 4'd0},
    {4'd4, 1'b0, 3'd6, 4'b1000, 1'b1, 4'd1},
    {4'd4, 1'b0, 3'd7, 4'b1111, 1'b0, 4'd0},
    {4'd5, 1'b0, 3'd0, 4'b1111, 1'b1, 4'd1},
    {4'd5, 1'b0, 3'd0, 4'b0111, 1'b1, 4'd2},
    {4'd5, 1'b0, 3'd0, 4'b0011, 1'b1, 4'd3},
    {4'd3, 1'b0, 3'd5, 4'b0011, 1'b0, 4'd0},
    {4'd5, 1'b0, 3'd4, 4'b0101, 1'b1, 4'd2},
    {4'd1, 1'b0 | 1'b1, 3'd0, 4'b1111, 1'b0, 4'd0},
    {4'd1, 1'b1, 3'd7, 4'b1000, 1'b0, 4'd0}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // Reference from the requirements: ceilings 3/4/5/6, rank mchk>ipi>clk>dev.
  function automatic logic [3:0] ref_cause(input logic p, input logic [2:0] l,
                                           input logic [3:0] r);
    if (p) return 4'd0;
    if (r[3] && l <= 3'd6) return 4'd1;
    if (r[2] && l <= 3'd5) return 4'd2;
    if (r[1] && l <= 3'd4) return 4'd3;
    if (r[0] && l <= 3'd3) return 4'd4;
    return 4'd0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic [2:0] l, input logic [3:0] r,
                       input logic wr, input logic [7:0] d);
    @(negedge clk);
    priv = p; ipl = l;
    {req_mchk, req_ipi, req_clk, req_dev} = r;
    err_wr = wr; err_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; priv = 1'b0; ipl = 3'd0;
    {req_mchk, req_ipi, req_clk, req_dev} = 4'b1111;
    err_wr = 1'b1; err_data = 8'h3C;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state while inputs are active
    check("R10", "take in reset", {7'd0, take}, 8'd0);
    check("R10", "cause in reset", {4'd0, cause}, 8'd0);
    check("R10", "err in reset", err_code, 8'd0);
    @(negedge clk);
    {req_mchk, req_ipi, req_clk, req_dev} = 4'b0000;
    err_wr = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Table walk: idle write of A5 before every vector, R7 timing on each
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, 3'd0, 4'b0000, 1'b1, 8'hA5);
      drive(VEC[i][12], VEC[i][11:9], VEC[i][8:5], 1'b0, 8'h00);
      check(tag_name(VEC[i][16:13]), "take", {7'd0, take}, {7'd0, VEC[i][4]});
      check("R6", "cause", {4'd0, cause}, {4'd0, VEC[i][3:0]});
      check("R9", "err", err_code, VEC[i][4] ? 8'h00 : 8'hA5);
    end

    // Exhaustive sweep against the reference
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 8; l++) begin
        for (int r = 0; r < 16; r++) begin
          logic [3:0] ec;
          ec = ref_cause(p[0], l[2:0], r[3:0]);
          drive(1'b0, 3'd0, 4'b0000, 1'b0, 8'h00);
          drive(p[0], l[2:0], r[3:0], 1'b0, 8'h00);
          check("R5", "sweep take", {7'd0, take}, {7'd0, (ec != 4'd0)});
          check("R6", "sweep cause", {4'd0, cause}, {4'd0, ec});
        end
      end
    end

    // R8: held clock request gives take, guard gap, take
    drive(1'b0, 3'd0, 4'b0000, 1'b0, 8'h00);
    drive(1'b0, 3'd2, 4'b0010, 1'b0, 8'h00);
    check("R7", "held req first", {7'd0, take}, 8'd1);
    drive(1'b0, 3'd2, 4'b0010, 1'b0, 8'h00);
    check("R8", "guard cycle take", {7'd0, take}, 8'd0);
    check("R8", "guard cycle cause", {4'd0, cause}, 8'd0);
    drive(1'b0, 3'd2, 4'b0010, 1'b0, 8'h00);
    check("R8", "resume take", {7'd0, take}, 8'd1);
    check("R8", "resume cause", {4'd0, cause}, 8'd3);

    // R7: output lasts one cycle once the request drops
    drive(1'b0, 3'd0, 4'b0000, 1'b0, 8'h00);
    check("R7", "pulse ends", {7'd0, take}, 8'd0);

    // R9: write alone loads, take beats a simultaneous write
    drive(1'b0, 3'd0, 4'b0000, 1'b1, 8'h5A);
    check("R9", "write loads", err_code, 8'h5A);
    drive(1'b0, 3'd0, 4'b1000, 1'b1, 8'hC3);
    check("R9", "take beats write", err_code, 8'h00);
    check("R9", "take with write", {7'd0, take}, 8'd1);
    drive(1'b0, 3'd0, 4'b0000, 1'b1, 8'h77);
    check("R9", "write after take", err_code, 8'h77);

    // R1: privileged mode holds off a pending machine check, then releases it
    drive(1'b1, 3'd0, 4'b1000, 1'b0, 8'h00);
    check("R1", "priv mchk", {7'd0, take}, 8'd0);
    check("R9", "err kept under priv", err_code, 8'h77);
    drive(1'b0, 3'd0, 4'b1000, 1'b0, 8'h00);
    check("R1", "priv released", {4'd0, cause}, 8'd1);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "async err clear", err_code, 8'd0);
    check("R10", "async take clear", {7'd0, take}, 8'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule